// File: doc/BRIEF.md
# Interrupt Requester-ID Validator

This block decides whether a remapped interrupt request may use the table entry it targets. The lookup logic supplies three fields from that entry, and the request supplies its own 16-bit requester ID. The fields are a 2-bit validation type, a 2-bit qualifier and a 16-bit source ID. The block returns a verdict: pass, or fail with a fault code. In every ID, bits 15:8 hold the bus number and bits 7:0 hold the device/function number. Table lookup and fault logging sit outside this block.

Three validation modes are supported. The first is no check. The second is an identity compare, in which the qualifier can mask some function-number bits. The third is a bus-window check, in which the source ID holds a first bus and a last bus rather than a device identity. A global override turns every check off. The decision logic is combinational and its result is registered, so each verdict appears exactly one clock after its request.

Top module: `rid_validator`

## Requirements
- R1: With validation type 0, the request passes with fault code 0, whatever the IDs are.
- R2: With validation type 1 and qualifier 0, the request passes only when all 16 bits of the requester ID equal the source ID. Otherwise it fails with fault code 1.
- R3: With validation type 1, qualifier 1 leaves bit 2 out of the compare, qualifier 2 leaves bits 2:1 out, and qualifier 3 leaves bits 2:0 out. A mismatch in any bit that is still compared fails with fault code 1.
- R4: With validation type 2, the request passes when the requester bus (bits 15:8) is at least the source ID's upper byte and at most its lower byte, both bounds included. Otherwise it fails with fault code 2, and this includes a window whose first bus is above its last bus.
- R5: With validation type 2, the qualifier has no effect on the verdict, and the requester's bits 7:0 have none either.
- R6: Validation type 3 is reserved, and a request with it always fails with fault code 3.
- R7: While the global disable input is high, every request passes with fault code 0. This holds for the reserved type as well.
- R8: A verdict appears one cycle after its request. `vldOut` follows `reqVld` with a one-cycle delay, and while `vldOut` is low, `passOut` is 0 and `faultOut` is 0.
- R9: After reset, `vldOut`, `passOut` and `faultOut` are all 0.
- R10: While `vldOut` is high, `passOut` is 1 exactly when `faultOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVld | input | 1 | A request is presented this cycle |
| reqId | input | 16 | Requester ID of the interrupt (bus in 15:8, device/function in 7:0) |
| valType | input | 2 | Validation type from the table entry |
| qualSel | input | 2 | Qualifier from the table entry |
| srcId | input | 16 | Source ID, or the bus window (first bus in 15:8, last bus in 7:0) |
| checkOff | input | 1 | Global disable of source validation |
| vldOut | output | 1 | A verdict is present |
| passOut | output | 1 | The request is allowed |
| faultOut | output | 2 | 0 none, 1 ID mismatch, 2 bus outside window, 3 reserved type |

## Verification
The override and the reserved type can both be active in one request, and the override must take priority. The bench provokes this by driving type 3 with `checkOff` high, and it expects a pass with fault code 0. The bus-window check and the qualifier can also be presented together. Type 2 requests are sent with qualifier 3 and with unrelated low requester bits, including cases where the bus sits exactly on each bound. The verdict must then depend on the bus number alone.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [1:0] {
    VT_NONE  = 2'd0,
    VT_EXACT = 2'd1,
    VT_BUSWIN = 2'd2,
    VT_RSVD  = 2'd3
  } valType_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ID   = 2'd1,
    FLT_BUS  = 2'd2,
    FLT_TYPE = 2'd3
  } fault_e;

  // strobes from control to datapath; at most one check strobe is active
  typedef struct packed {
    logic live;
    logic bypass;
    logic idCheck;
    logic busCheck;
    logic rsvd;
  } ctrlStrobes_t;
endpackage

// File: rtl/rid_ctrl.sv
module rid_ctrl
  import rid_pkg::*;
#(
  parameter int TYPE_W = 2
) (
  input  logic              reqVld,
  input  logic [TYPE_W-1:0] valType,
  input  logic              checkOff,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    strobes.live = reqVld;
    if (reqVld) begin
      if (checkOff || valType == VT_NONE) begin
        strobes.bypass = 1'b1;
      end else begin
        unique case (valType)
          VT_EXACT:  strobes.idCheck  = 1'b1;
          VT_BUSWIN: strobes.busCheck = 1'b1;
          default:   strobes.rsvd     = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/rid_dp.sv
module rid_dp
  import rid_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int DEVFN_W = 8,
  parameter int FN_W    = 3,
  parameter int QUAL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ID_W-1:0]   reqId,
  input  logic [QUAL_W-1:0] qualSel,
  input  logic [ID_W-1:0]   srcId,
  output logic              vldOut,
  output logic              passOut,
  output logic [1:0]        faultOut
);
  localparam int BUS_W = ID_W - DEVFN_W;

  logic [ID_W-1:0]  keepMask;
  logic             idMatch;
  logic [BUS_W-1:0] reqBus, firstBus, lastBus;
  logic             busInWin;
  fault_e           nextFault;

  // qualifier q drops the q highest function-number bits from the compare
  always_comb begin
    for (int i = 0; i < ID_W; i++) begin
      keepMask[i] = !((i < FN_W) && (i >= FN_W - int'(qualSel)));
    end
  end

  assign idMatch  = ((reqId ^ srcId) & keepMask) == '0;
  assign reqBus   = reqId[ID_W-1:DEVFN_W];
  assign firstBus = srcId[ID_W-1:DEVFN_W];
  assign lastBus  = srcId[BUS_W-1:0];
  assign busInWin = (reqBus >= firstBus) && (reqBus <= lastBus);

  always_comb begin
    nextFault = FLT_NONE;
    if (strobes.rsvd)                        nextFault = FLT_TYPE;
    else if (strobes.idCheck && !idMatch)    nextFault = FLT_ID;
    else if (strobes.busCheck && !busInWin)  nextFault = FLT_BUS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldOut   <= 1'b0;
      passOut  <= 1'b0;
      faultOut <= 2'd0;
    end else begin
      vldOut   <= strobes.live;
      passOut  <= strobes.live && (nextFault == FLT_NONE);
      faultOut <= strobes.live ? nextFault : FLT_NONE;
    end
  end
endmodule

// File: rtl/rid_validator.sv
module rid_validator
  import rid_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int DEVFN_W = 8,
  parameter int FN_W    = 3,
  parameter int TYPE_W  = 2,
  parameter int QUAL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqVld,
  input  logic [ID_W-1:0]   reqId,
  input  logic [TYPE_W-1:0] valType,
  input  logic [QUAL_W-1:0] qualSel,
  input  logic [ID_W-1:0]   srcId,
  input  logic              checkOff,
  output logic              vldOut,
  output logic              passOut,
  output logic [1:0]        faultOut
);
  ctrlStrobes_t strobes;

  rid_ctrl #(.TYPE_W(TYPE_W)) u_ctrl (
    .reqVld(reqVld), .valType(valType), .checkOff(checkOff), .strobes(strobes)
  );

  rid_dp #(.ID_W(ID_W), .DEVFN_W(DEVFN_W), .FN_W(FN_W), .QUAL_W(QUAL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqId(reqId), .qualSel(qualSel),
    .srcId(srcId), .vldOut(vldOut), .passOut(passOut), .faultOut(faultOut)
  );
endmodule

// File: rtl/rid_validator_chk.sv
module rid_validator_chk #(
  parameter int ID_W   = 16,
  parameter int TYPE_W = 2,
  parameter int QUAL_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqVld,
  input logic [ID_W-1:0]   reqId,
  input logic [TYPE_W-1:0] valType,
  input logic [QUAL_W-1:0] qualSel,
  input logic [ID_W-1:0]   srcId,
  input logic              checkOff,
  input logic              vldOut,
  input logic              passOut,
  input logic [1:0]        faultOut
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqVld |=> vldOut);                                        // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !vldOut |-> (!passOut && faultOut == 2'd0));               // R8
  AST_PASS_IFF_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    vldOut |-> (passOut == (faultOut == 2'd0)));               // R10
  AST_NO_CHECK_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqVld && valType == 2'd0) |=> passOut);                  // R1
  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (reqVld && valType == 2'd3 && !checkOff) |=> faultOut == 2'd3); // R6
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqVld && checkOff) |=> (passOut && faultOut == 2'd0));   // R7
endmodule

bind rid_validator rid_validator_chk #(.ID_W(ID_W), .TYPE_W(TYPE_W), .QUAL_W(QUAL_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqVld(reqVld), .reqId(reqId), .valType(valType),
  .qualSel(qualSel), .srcId(srcId), .checkOff(checkOff), .vldOut(vldOut),
  .passOut(passOut), .faultOut(faultOut)
);

// File: tb/sim_rid_validator.sv
`timescale 1ns/1ps
module sim_rid_validator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqVld = 1'b0;
  logic [15:0] reqId = '0;
  logic [1:0]  valType = '0;
  logic [1:0]  qualSel = '0;
  logic [15:0] srcId = '0;
  logic        checkOff = 1'b0;
  logic        vldOut, passOut;
  logic [1:0]  faultOut;

  int nChecks = 0;
  int nFails = 0;
  bit running = 1'b0;

  typedef struct {
    logic       vld;
    logic       pass;
    logic [1:0] fault;
    string      tag;
  } expItem_t;
  expItem_t scoreQ[$];

  always #4 clk = ~clk;

  rid_validator u0 (
    .clk(clk), .rstN(rstN), .reqVld(reqVld), .reqId(reqId), .valType(valType),
    .qualSel(qualSel), .srcId(srcId), .checkOff(checkOff), .vldOut(vldOut),
    .passOut(passOut), .faultOut(faultOut)
  );

  // reference model written from the requirements
  function automatic expItem_t model(logic v, logic [1:0] t, logic [1:0] q,
                                     logic [15:0] rid, logic [15:0] sid,
                                     logic off, string tag);
    expItem_t e;
    logic [15:0] msk;
    e.vld = v; e.pass = 1'b0; e.fault = 2'd0; e.tag = tag;
    if (!v) return e;
    if (off || t == 2'd0) begin
      e.pass = 1'b1;
    end else if (t == 2'd1) begin
      case (q)
        2'd0: msk = 16'hFFFF;
        2'd1: msk = 16'hFFFB;
        2'd2: msk = 16'hFFF9;
        default: msk = 16'hFFF8;
      endcase
      if ((rid & msk) == (sid & msk)) e.pass = 1'b1; else e.fault = 2'd1;
    end else if (t == 2'd2) begin
      if (rid[15:8] >= sid[15:8] && rid[15:8] <= sid[7:0]) e.pass = 1'b1;
      else e.fault = 2'd2;
    end else begin
      e.fault = 2'd3;
    end
    return e;
  endfunction

  task automatic step(logic v, logic [1:0] t, logic [1:0] q, logic [15:0] rid,
                      logic [15:0] sid, logic off, string tag);
    @(negedge clk);
    reqVld = v; valType = t; qualSel = q; reqId = rid; srcId = sid; checkOff = off;
    scoreQ.push_back(model(v, t, q, rid, sid, off, tag));
  endtask

  // monitor: results sampled 2 ns after the edge that registered them
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (running && scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        nChecks++;
        if (vldOut !== e.vld || passOut !== e.pass || faultOut !== e.fault) begin
          nFails++;
          $display("FAIL %s: got vld=%0b pass=%0b fault=%0d, expected vld=%0b pass=%0b fault=%0d",
                   e.tag, vldOut, passOut, faultOut, e.vld, e.pass, e.fault);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nFails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;  // R9 reset state
    if (vldOut !== 1'b0 || passOut !== 1'b0 || faultOut !== 2'd0) begin
      nFails++;
      $display("FAIL R9: got vld=%0b pass=%0b fault=%0d, expected 0 0 0", vldOut, passOut, faultOut);
    end
    running = 1'b1;
    step(1, 0, 2, 16'h1234, 16'hABCD, 0, "R1");
    step(0, 1, 0, 16'h1234, 16'h9999, 0, "R8");
    step(1, 1, 0, 16'h0A17, 16'h0A17, 0, "R2");
    step(1, 1, 0, 16'h0A16, 16'h0A17, 0, "R2");
    step(1, 1, 0, 16'h8A17, 16'h0A17, 0, "R2");
    step(1, 1, 1, 16'h0A13, 16'h0A17, 0, "R3");
    step(1, 1, 1, 16'h0A15, 16'h0A17, 0, "R3");
    step(1, 1, 2, 16'h0A11, 16'h0A17, 0, "R3");
    step(1, 1, 2, 16'h0A16, 16'h0A17, 0, "R3");
    step(1, 1, 3, 16'h0A10, 16'h0A17, 0, "R3");
    step(1, 1, 3, 16'h0A1F, 16'h0A17, 0, "R3");
    step(1, 2, 0, 16'h2000, 16'h2030, 0, "R4");
    step(1, 2, 0, 16'h30FF, 16'h2030, 0, "R4");
    step(1, 2, 0, 16'h1FFF, 16'h2030, 0, "R4");
    step(1, 2, 0, 16'h3100, 16'h2030, 0, "R4");
    step(1, 2, 0, 16'h2500, 16'h3020, 0, "R4");
    step(1, 2, 3, 16'h2A5E, 16'h2030, 0, "R5");
    step(1, 2, 1, 16'h20C3, 16'h2020, 0, "R5");
    step(1, 2, 2, 16'h2107, 16'h2020, 0, "R5");
    step(1, 3, 0, 16'h0A17, 16'h0A17, 0, "R6");
    step(1, 3, 3, 16'h0000, 16'h0000, 0, "R6");
    step(1, 3, 0, 16'h0A17, 16'h0B00, 1, "R7");
    step(1, 1, 0, 16'h0A17, 16'hFFFF, 1, "R7");
    step(1, 2, 0, 16'h9900, 16'h1010, 1, "R7");
    step(0, 3, 0, 16'h0000, 16'h0000, 0, "R8");
    step(1, 1, 0, 16'h4444, 16'h4444, 0, "R10");
    for (int k = 0; k < 300; k++) begin
      logic [15:0] r, s;
      r = 16'($urandom());
      s = ($urandom() % 2 == 0) ? (r ^ 16'(1 << ($urandom() % 4))) : 16'($urandom());
      step(1'($urandom() % 5 != 0), 2'($urandom()), 2'($urandom()), r, s,
           1'($urandom() % 7 == 0), "R10 random");
    end
    step(0, 0, 0, 16'h0, 16'h0, 0, "R8");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule